// File: doc/BRIEF.md
# Trap and Exception Control Unit

This block sits beside the pipeline of a small 32-bit in-order processor and owns every transfer of control into the operating system. The datapath raises a request carrying a reason code, the PC of the faulting instruction and, where relevant, the virtual address that faulted. The block records these in its exception registers, switches the processor into kernel mode, masks further exceptions and steers fetch to a fixed handler address. A return-from-exception operation in kernel mode sends fetch back to the saved PC, drops to user mode and unmasks exceptions in the same cycle.

Kernel software reaches the exception registers through single-cycle coprocessor reads and writes. In user mode, any coprocessor access, return or other privileged operation becomes an illegal-instruction trap. A fault taken while exceptions are masked leaves the saved state alone and goes to a separate double-fault entry. A fault inside the double-fault handler stops the block and raises a sticky shutdown output.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in kernel mode with exceptions enabled and shutdown low. During reset, redirect_o is high with redirect_pc_o equal to the boot address 0xBFC00000. Status reads 0x3 after reset.
- R2: A trap taken with exceptions enabled stores pc_i in EPC and the code in Cause, enters kernel mode and clears the enable bit. In the next cycle redirect_o pulses with redirect_pc_o = 0x80000180.
- R3: BadVAddr loads badva_i only on a normal trap whose code is 4 (address error), 13 (page fault) or 14 (protection fault). Every other trap leaves it unchanged.
- R4: The recognised codes are 0 timer tick, 4, 8 syscall, 10 illegal instruction, 12 overflow, 13, 14 and 15 divide-by-zero. Any other requested code is recorded as 10.
- R5: eret_i in kernel mode redirects to the current EPC in the next cycle, including a value written the cycle before. It selects user mode, sets the enable bit and clears the double-fault flag.
- R6: In user mode, cp_re_i, cp_we_i, eret_i or priv_op_i raises an illegal-instruction trap (code 10) at pc_i. Write data is discarded and no return happens.
- R7: Coprocessor address 8 is BadVAddr, 12 is Status (bit 0 enable, bit 1 kernel, bit 2 double fault), 13 is Cause (code in bits 4:0) and 14 is EPC. Kernel writes to EPC, and to Status bits 0 and 1, take effect the next cycle. Writes elsewhere are ignored, and unmapped addresses read 0.
- R8: A trap while exceptions are masked and no double fault is active leaves EPC, Cause and BadVAddr unchanged. It sets the double-fault flag, stays in kernel mode and redirects to 0x80000200.
- R9: A trap while the double-fault flag is set raises shutdown_o, which stays high until reset. While shut down there are no redirects and no register changes.
- R10: A trap request has priority over a return or a register write in the same cycle. Both of those are dropped.
- R11: A privileged operation in kernel mode causes no trap and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request from the datapath |
| exc_cause_i | input | 5 | Requested reason code |
| pc_i | input | 32 | PC of the instruction being acted on |
| badva_i | input | 32 | Faulting virtual address |
| cp_re_i | input | 1 | Coprocessor register read |
| cp_we_i | input | 1 | Coprocessor register write |
| cp_addr_i | input | 5 | Coprocessor register address |
| cp_wdata_i | input | 32 | Coprocessor write data |
| eret_i | input | 1 | Return from exception |
| priv_op_i | input | 1 | Other privileged operation (TLB, cache, halt) |
| cp_rdata_o | output | 32 | Coprocessor read data (combinational) |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| kernel_mode_o | output | 1 | 1 = kernel, 0 = user |
| shutdown_o | output | 1 | Sticky halt after a triple fault |

## Verification
The hardest state to reach is the triple fault. The bench must first take a normal trap and then raise a second fault while the first handler is still masked. It must then show that the saved EPC, Cause and BadVAddr from the first fault survive, and only then raise a third fault. The stimulus table walks this sequence without a reset in between. It reads the registers back between the steps and then confirms that neither a return nor a write can revive the block. A further sequence returns from a double fault and traps again, proving the return cleared the flag. It also pairs a trap request with a return and a write in one cycle to show which one wins.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [4:0] CAUSE_TICK = 5'd0;
  localparam logic [4:0] CAUSE_ADDR = 5'd4;
  localparam logic [4:0] CAUSE_SYS  = 5'd8;
  localparam logic [4:0] CAUSE_ILL  = 5'd10;
  localparam logic [4:0] CAUSE_OVF  = 5'd12;
  localparam logic [4:0] CAUSE_PGF  = 5'd13;
  localparam logic [4:0] CAUSE_PROT = 5'd14;
  localparam logic [4:0] CAUSE_DIV  = 5'd15;

  localparam int REG_BADVA  = 8;
  localparam int REG_STATUS = 12;
  localparam int REG_CAUSE  = 13;
  localparam int REG_EPC    = 14;

  localparam int ST_IE  = 0;
  localparam int ST_KRN = 1;
  localparam int ST_DBL = 2;

  typedef enum logic [1:0] {
    ESC_NONE,
    ESC_NORMAL,
    ESC_DOUBLE,
    ESC_HALT
  } esc_e;
endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
  import trap_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic               req_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               viol_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] code_o,
  output logic               badva_we_o
);
  logic known;

  always_comb begin
    unique case (cause_i)
      CAUSE_TICK, CAUSE_ADDR, CAUSE_SYS, CAUSE_ILL,
      CAUSE_OVF, CAUSE_PGF, CAUSE_PROT, CAUSE_DIV: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  // a datapath request outranks a privilege violation
  assign take_o     = req_i | viol_i;
  assign code_o     = (req_i && known) ? cause_i : CAUSE_W'(CAUSE_ILL);
  assign badva_we_o = req_i && (code_o == CAUSE_ADDR || code_o == CAUSE_PGF ||
                                code_o == CAUSE_PROT);
endmodule

// File: rtl/trap_escalate.sv
module trap_escalate
  import trap_pkg::*;
(
  input  logic take_i,
  input  logic live_i,
  input  logic ie_i,
  input  logic dbl_i,
  output esc_e esc_o
);
  always_comb begin
    esc_o = ESC_NONE;
    if (live_i && take_i) begin
      if (dbl_i)     esc_o = ESC_HALT;
      else if (ie_i) esc_o = ESC_NORMAL;
      else           esc_o = ESC_DOUBLE;
    end
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  esc_e               esc_i,
  input  logic               badva_we_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    badva_i,
  input  logic               eret_ok_i,
  input  logic               we_ok_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [XLEN-1:0]    wdata_i,
  output logic [XLEN-1:0]    epc_o,
  output logic               ie_o,
  output logic               kernel_o,
  output logic               dbl_o,
  output logic               halted_o,
  output logic [XLEN-1:0]    rdata_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic [XLEN-1:0]    badva_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o    <= '0;
      cause_q  <= '0;
      badva_q  <= '0;
      ie_o     <= 1'b1;
      kernel_o <= 1'b1;
      dbl_o    <= 1'b0;
      halted_o <= 1'b0;
    end else if (!halted_o) begin
      unique case (esc_i)
        ESC_HALT: halted_o <= 1'b1;
        ESC_NORMAL: begin
          epc_o    <= pc_i;
          cause_q  <= code_i;
          if (badva_we_i) badva_q <= badva_i;
          kernel_o <= 1'b1;
          ie_o     <= 1'b0;
        end
        ESC_DOUBLE: begin
          dbl_o    <= 1'b1;
          kernel_o <= 1'b1;
        end
        default: begin
          if (eret_ok_i) begin
            kernel_o <= 1'b0;
            ie_o     <= 1'b1;
            dbl_o    <= 1'b0;
          end else if (we_ok_i) begin
            if (addr_i == ADDR_W'(REG_EPC)) epc_o <= wdata_i;
            if (addr_i == ADDR_W'(REG_STATUS)) begin
              ie_o     <= wdata_i[ST_IE];
              kernel_o <= wdata_i[ST_KRN];
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_EPC))   rdata_o = epc_o;
    if (addr_i == ADDR_W'(REG_CAUSE)) rdata_o = XLEN'(cause_q);
    if (addr_i == ADDR_W'(REG_BADVA)) rdata_o = badva_q;
    if (addr_i == ADDR_W'(REG_STATUS)) begin
      rdata_o[ST_IE]  = ie_o;
      rdata_o[ST_KRN] = kernel_o;
      rdata_o[ST_DBL] = dbl_o;
    end
  end

  // R8
  dbl_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_i == ESC_DOUBLE) |=> ($stable(epc_o) && $stable(cause_q) && $stable(badva_q) && dbl_o));

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(epc_o) && $stable(cause_q) && $stable(kernel_o)));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CAUSE_W   = 5,
  parameter int          ADDR_W    = 5,
  parameter logic [31:0] BOOT_ADDR = 32'hBFC0_0000,
  parameter logic [31:0] EXC_VEC   = 32'h8000_0180,
  parameter logic [31:0] DBL_VEC   = 32'h8000_0200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    badva_i,
  input  logic               cp_re_i,
  input  logic               cp_we_i,
  input  logic [ADDR_W-1:0]  cp_addr_i,
  input  logic [XLEN-1:0]    cp_wdata_i,
  input  logic               eret_i,
  input  logic               priv_op_i,
  output logic [XLEN-1:0]    cp_rdata_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               kernel_mode_o,
  output logic               shutdown_o
);
  logic               viol, take, badva_we, live, eret_ok, we_ok;
  logic               ie, dbl, kernel, halted;
  logic [CAUSE_W-1:0] code;
  logic [XLEN-1:0]    epc;
  esc_e               esc;

  assign live = !halted;
  assign viol = !kernel && (cp_re_i || cp_we_i || eret_i || priv_op_i);

  trap_cause_map #(.CAUSE_W(CAUSE_W)) u_map (
    .req_i      (exc_req_i),
    .cause_i    (exc_cause_i),
    .viol_i     (viol),
    .take_o     (take),
    .code_o     (code),
    .badva_we_o (badva_we)
  );

  trap_escalate u_esc (
    .take_i (take),
    .live_i (live),
    .ie_i   (ie),
    .dbl_i  (dbl),
    .esc_o  (esc)
  );

  assign eret_ok = live && kernel && eret_i && !take;
  assign we_ok   = live && kernel && cp_we_i && !take;

  trap_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .esc_i      (esc),
    .badva_we_i (badva_we),
    .code_i     (code),
    .pc_i       (pc_i),
    .badva_i    (badva_i),
    .eret_ok_i  (eret_ok),
    .we_ok_i    (we_ok),
    .addr_i     (cp_addr_i),
    .wdata_i    (cp_wdata_i),
    .epc_o      (epc),
    .ie_o       (ie),
    .kernel_o   (kernel),
    .dbl_o      (dbl),
    .halted_o   (halted),
    .rdata_o    (cp_rdata_o)
  );

  // reset value doubles as the boot redirect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b1;
      redirect_pc_o <= XLEN'(BOOT_ADDR);
    end else begin
      redirect_o <= (esc == ESC_NORMAL) || (esc == ESC_DOUBLE) || eret_ok;
      unique case (esc)
        ESC_NORMAL: redirect_pc_o <= XLEN'(EXC_VEC);
        ESC_DOUBLE: redirect_pc_o <= XLEN'(DBL_VEC);
        default:    redirect_pc_o <= epc;
      endcase
    end
  end

  assign kernel_mode_o = kernel;
  assign shutdown_o    = halted;

  // R2
  normal_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !shutdown_o && ie && !dbl) |=>
      (redirect_o && redirect_pc_o == XLEN'(EXC_VEC) && kernel_mode_o && !ie));

  // R5
  eret_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && kernel_mode_o && !exc_req_i && !shutdown_o) |=>
      (redirect_o && !kernel_mode_o && ie && !dbl));

  // R6
  user_priv_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kernel_mode_o && !shutdown_o && (cp_we_i || cp_re_i || priv_op_i)) |=>
      (kernel_mode_o && (redirect_o || shutdown_o)));

  // R9
  shut_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !redirect_o);
endmodule

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  localparam logic [31:0] V = 32'h8000_0180;
  localparam logic [31:0] D = 32'h8000_0200;
  localparam logic [31:0] B = 32'hBFC0_0000;

  localparam logic [2:0] O_IDLE = 3'd0, O_EXC = 3'd1, O_ERET = 3'd2, O_WR = 3'd3,
                         O_RD = 3'd4, O_PRIV = 3'd5, O_RST = 3'd6, O_MIX = 3'd7;

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  cause;
    logic [31:0] pc;
    logic [31:0] va;
    logic [4:0]  addr;
    logic [31:0] wd;
    logic        rd_chk;
    logic        redir;
    logic [31:0] tgt;
    logic        kern;
    logic        shut;
    logic [31:0] rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 54;
  localparam vec_t TBL [NV] = '{
    '{O_RST, 0, 0, 0, 0, 0, 0, 1, B, 1, 0, 0, 1},                                 // R1
    '{O_RD, 0, 0, 0, 12, 0, 1, 0, 0, 1, 0, 32'h3, 1},                             // R1
    '{O_WR, 0, 0, 0, 14, 32'h0040_0000, 0, 0, 0, 1, 0, 0, 7},                     // R7
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0000, 0, 0, 0, 5},                    // R5
    '{O_EXC, 8, 32'h0040_0010, 32'hAAAA_0000, 0, 0, 0, 1, V, 1, 0, 0, 2},         // R2
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 0, 32'h0040_0010, 2},                     // R2
    '{O_RD, 0, 0, 0, 13, 0, 1, 0, 0, 1, 0, 32'd8, 2},                             // R2
    '{O_RD, 0, 0, 0, 8, 0, 1, 0, 0, 1, 0, 32'h0, 3},                              // R3
    '{O_RD, 0, 0, 0, 12, 0, 1, 0, 0, 1, 0, 32'h2, 2},                             // R2
    '{O_WR, 0, 0, 0, 14, 32'h0040_0014, 0, 0, 0, 1, 0, 0, 7},                     // R7
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0014, 0, 0, 0, 5},                    // R5
    '{O_EXC, 13, 32'h0040_0020, 32'h1234_5678, 0, 0, 0, 1, V, 1, 0, 0, 3},        // R3
    '{O_RD, 0, 0, 0, 8, 0, 1, 0, 0, 1, 0, 32'h1234_5678, 3},                      // R3
    '{O_EXC, 15, 32'h8000_0190, 32'h55, 0, 0, 0, 1, D, 1, 0, 0, 8},               // R8
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 0, 32'h0040_0020, 8},                     // R8
    '{O_RD, 0, 0, 0, 13, 0, 1, 0, 0, 1, 0, 32'd13, 8},                            // R8
    '{O_RD, 0, 0, 0, 12, 0, 1, 0, 0, 1, 0, 32'h6, 8},                             // R8
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0020, 0, 0, 0, 5},                    // R5
    '{O_EXC, 12, 32'h0040_0020, 32'h99, 0, 0, 0, 1, V, 1, 0, 0, 5},               // R5
    '{O_RD, 0, 0, 0, 12, 0, 1, 0, 0, 1, 0, 32'h2, 5},                             // R5
    '{O_EXC, 14, 32'h8000_0184, 32'h7777_0000, 0, 0, 0, 1, D, 1, 0, 0, 8},        // R8
    '{O_RD, 0, 0, 0, 8, 0, 1, 0, 0, 1, 0, 32'h1234_5678, 8},                      // R8
    '{O_EXC, 12, 32'h8000_0204, 0, 0, 0, 0, 0, 0, 1, 1, 0, 9},                    // R9
    '{O_ERET, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 9},                                // R9
    '{O_WR, 0, 0, 0, 14, 32'h1, 0, 0, 0, 1, 1, 0, 9},                             // R9
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 1, 32'h0040_0020, 9},                     // R9
    '{O_RST, 0, 0, 0, 0, 0, 0, 1, B, 1, 0, 0, 1},                                 // R1
    '{O_WR, 0, 0, 0, 14, 32'h0040_0100, 0, 0, 0, 1, 0, 0, 7},                     // R7
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0100, 0, 0, 0, 5},                    // R5
    '{O_WR, 0, 32'h0040_0104, 0, 14, 32'hDEAD_BEEF, 0, 1, V, 1, 0, 0, 6},         // R6
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 0, 32'h0040_0104, 6},                     // R6
    '{O_RD, 0, 0, 0, 13, 0, 1, 0, 0, 1, 0, 32'd10, 6},                            // R6
    '{O_WR, 0, 0, 0, 14, 32'h0040_0200, 0, 0, 0, 1, 0, 0, 7},                     // R7
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0200, 0, 0, 0, 5},                    // R5
    '{O_EXC, 7, 32'h0040_0204, 0, 0, 0, 0, 1, V, 1, 0, 0, 4},                     // R4
    '{O_RD, 0, 0, 0, 13, 0, 1, 0, 0, 1, 0, 32'd10, 4},                            // R4
    '{O_WR, 0, 0, 0, 12, 32'h1, 0, 0, 0, 0, 0, 0, 7},                             // R7
    '{O_PRIV, 0, 32'h0040_0300, 0, 0, 0, 0, 1, V, 1, 0, 0, 6},                    // R6
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 0, 32'h0040_0300, 6},                     // R6
    '{O_PRIV, 0, 32'h8000_0400, 0, 0, 0, 0, 0, 0, 1, 0, 0, 11},                   // R11
    '{O_WR, 0, 0, 0, 13, 32'h1F, 0, 0, 0, 1, 0, 0, 7},                            // R7
    '{O_RD, 0, 0, 0, 13, 0, 1, 0, 0, 1, 0, 32'd10, 7},                            // R7
    '{O_RD, 0, 0, 0, 3, 0, 1, 0, 0, 1, 0, 32'h0, 7},                              // R7
    '{O_WR, 0, 0, 0, 14, 32'h0040_0400, 0, 0, 0, 1, 0, 0, 7},                     // R7
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0400, 0, 0, 0, 5},                    // R5
    '{O_RD, 0, 32'h0040_0404, 0, 12, 0, 0, 1, V, 1, 0, 0, 6},                     // R6
    '{O_WR, 0, 0, 0, 14, 32'h0040_0500, 0, 0, 0, 1, 0, 0, 7},                     // R7
    '{O_ERET, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0500, 0, 0, 0, 5},                    // R5
    '{O_MIX, 0, 32'h0040_0500, 0, 14, 32'h99, 0, 1, V, 1, 0, 0, 10},              // R10
    '{O_RD, 0, 0, 0, 13, 0, 1, 0, 0, 1, 0, 32'd0, 10},                            // R10
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 0, 32'h0040_0500, 10},                    // R10
    '{O_MIX, 4, 32'h8000_0300, 32'h3, 14, 32'h99, 0, 1, D, 1, 0, 0, 10},          // R10
    '{O_RD, 0, 0, 0, 14, 0, 1, 0, 0, 1, 0, 32'h0040_0500, 10},                    // R10
    '{O_RD, 0, 0, 0, 12, 0, 1, 0, 0, 1, 0, 32'h6, 8}                              // R8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [4:0]  exc_cause_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] badva_i = '0;
  logic        cp_re_i = 1'b0;
  logic        cp_we_i = 1'b0;
  logic [4:0]  cp_addr_i = '0;
  logic [31:0] cp_wdata_i = '0;
  logic        eret_i = 1'b0;
  logic        priv_op_i = 1'b0;
  logic [31:0] cp_rdata_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic        kernel_mode_o;
  logic        shutdown_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4ns clk_i = ~clk_i;

  trap_ctrl uut (
    .clk_i, .rst_ni, .exc_req_i, .exc_cause_i, .pc_i, .badva_i,
    .cp_re_i, .cp_we_i, .cp_addr_i, .cp_wdata_i, .eret_i, .priv_op_i,
    .cp_rdata_o, .redirect_o, .redirect_pc_o, .kernel_mode_o, .shutdown_o
  );

  task automatic drive(input vec_t v);
    rst_ni      = (v.op != O_RST);
    exc_req_i   = (v.op == O_EXC) || (v.op == O_MIX);
    eret_i      = (v.op == O_ERET) || (v.op == O_MIX);
    cp_we_i     = (v.op == O_WR) || (v.op == O_MIX);
    cp_re_i     = (v.op == O_RD);
    priv_op_i   = (v.op == O_PRIV);
    exc_cause_i = v.cause;
    pc_i        = v.pc;
    badva_i     = v.va;
    cp_addr_i   = v.addr;
    cp_wdata_i  = v.wd;
  endtask

  task automatic check(input int idx, input vec_t v);
    logic [66:0] act, exp;
    act = {redirect_o, v.redir ? redirect_pc_o : 32'h0, kernel_mode_o, shutdown_o,
           v.rd_chk ? cp_rdata_o : 32'h0};
    exp = {v.redir, v.tgt, v.kern, v.shut, v.rd_chk ? v.rd : 32'h0};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d row %0d: act redir=%0b pc=%h k=%0b sd=%0b rd=%h exp redir=%0b pc=%h k=%0b sd=%0b rd=%h",
               v.req, idx, act[66], act[65:34], act[33], act[32], act[31:0],
               exp[66], exp[65:34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk_i);
      check(i, TBL[i]);
    end

    // R1: asynchronous reset from a double-faulted state, observed before any edge
    drive('{O_IDLE, 0, 0, 0, 12, 0, 0, 0, 0, 0, 0, 0, 0});
    cp_re_i = 1'b1;
    #1ns rst_ni = 1'b0;
    #1ns;
    n_run++;
    if (!(redirect_o === 1'b1 && redirect_pc_o === B && kernel_mode_o === 1'b1 &&
          shutdown_o === 1'b0 && cp_rdata_o === 32'h3)) begin
      n_fail++;
      $display("FAIL R1 async reset: act redir=%0b pc=%h st=%h exp redir=1 pc=%h st=3",
               redirect_o, redirect_pc_o, cp_rdata_o, B);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: boot redirect lasts only until the first active edge
    n_run++;
    if (redirect_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 boot pulse: act redir=%0b exp redir=0", redirect_o);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule